// File: doc/BRIEF.md
# Mode-Dependent Programmable Watchdog

This block is a watchdog timer for a system controller that runs in several operating modes. Software restarts it through a trigger strobe, which comes from a register write elsewhere. A millisecond tick input advances it. The nominal period comes from a 3-bit code. The scale of that code is not uniform: it doubles from 8 ms up to 256 ms, then jumps to 1024 ms and 4096 ms.

The kind of supervision is not fixed. It follows from a stored mode-control bit and the current operating mode:

- In Normal mode the bit selects window supervision or timeout supervision.
- In Standby the same bit selects timeout supervision or no supervision at all.
- Sleep and over-temperature always switch the watchdog off.

An external disable pin also forces the watchdog off, sets a status flag and requests a software reset. Any fault produces a one-cycle reset request for a pulse shaper downstream: expiry, an early trigger in window operation, or the disable pin going high.

Top module: `mode_watchdog`

## Requirements
- R1: The period code maps to a nominal period counted in millisecond ticks: 0→8, 1→16, 2→32, 3→64, 4→128, 5→256, 6→1024, 7→4096. In timeout operation with no trigger, `rstReq` rises exactly one cycle after the period-th tick that follows a restart.
- R2: Reset sets `periodCode` to 4 (128 ms) and `modeBit` to 0 and clears the counter. A cycle with `cfgWe` high loads `cfgPeriod` and `cfgMode` into them.
- R3: `wdKind` reports the active supervision, encoded 0 = off, 1 = window, 2 = timeout. With `disablePin` low: Normal (`opMode` 0) gives window when `modeBit` is 0 and timeout when it is 1. Standby (`opMode` 1) gives timeout when `modeBit` is 0 and off when it is 1. While off, ticks never produce a reset request.
- R4: In Sleep (`opMode` 2) and over-temperature (`opMode` 3), `wdKind` is 0, the counter is held at zero, and no tick or trigger produces a reset request.
- R5: In window operation, a trigger while fewer than half the period's ticks have elapsed requests a reset one cycle later. A trigger at or after half the period restarts the count with no request.
- R6: In window or timeout operation, if a tick arrives with period−1 ticks elapsed and there is no trigger in that cycle, `rstReq` is high in the next cycle and the count restarts.
- R7: While `disablePin` is high, `wdKind` is 0. `offStatus` follows the pin with one cycle of delay. Each low-to-high change of the pin gives a one-cycle `rstReq`.
- R8: A write that changes the period code or the mode bit restarts the count from zero in that cycle without a reset request, and so does any change of `opMode`.
- R9: In timeout operation, a trigger at any point of the period restarts the count with no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| msTick | input | 1 | One-cycle millisecond tick |
| trigger | input | 1 | Watchdog service strobe |
| cfgWe | input | 1 | Load strobe for period code and mode bit |
| cfgPeriod | input | 3 | New period code |
| cfgMode | input | 1 | New mode-control bit |
| opMode | input | 2 | Operating mode: 0 Normal, 1 Standby, 2 Sleep, 3 over-temperature |
| disablePin | input | 1 | External watchdog disable, active high |
| rstReq | output | 1 | One-cycle reset request |
| offStatus | output | 1 | Registered copy of the disable pin |
| wdKind | output | 2 | Active supervision: 0 off, 1 window, 2 timeout |
| periodCode | output | 3 | Stored period code |
| modeBit | output | 1 | Stored mode-control bit |

## Verification
The checker watches several properties on every cycle:

- the counter stays below the decoded period;
- an early trigger in window operation is always followed by a request;
- a quiet off state never raises one;
- any configuration or mode change leaves the counter at zero;
- the disable pin both sets the status flag and produces its request.

The exact expiry distance for each period code, the legal half-period boundary, and the supervision kind across the mode and bit combinations are shown only by the bench's directed scenarios. The bench also runs long random sequences against its own reference model.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  typedef enum logic [1:0] {
    OP_NORMAL   = 2'd0,
    OP_STANDBY  = 2'd1,
    OP_SLEEP    = 2'd2,
    OP_OVERTEMP = 2'd3
  } opMode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_WINDOW  = 2'd1,
    WD_TIMEOUT = 2'd2
  } wdKind_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } cntCmd_t;

endpackage

// File: rtl/mwd_datapath.sv
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int BASE_MS    = 8,
  parameter int LONG_MS    = 1024,
  parameter int LONGEST_MS = 4096,
  parameter int RST_CODE   = 4,
  parameter int CNT_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgPeriod,
  input  logic              cfgMode,
  input  cntCmd_t           cmd,
  output logic [CODE_W-1:0] periodCode,
  output logic              modeBit,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  periodMs,
  output logic              upperHalf,
  output logic              lastTick,
  output logic              cfgChanged
);

  localparam int NUM_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] halfMs;

  // Geometric scale for the low codes, two fixed long periods on top
  always_comb begin
    if (periodCode == CODE_W'(NUM_CODES - 1)) begin
      periodMs = CNT_W'(LONGEST_MS);
    end else if (periodCode == CODE_W'(NUM_CODES - 2)) begin
      periodMs = CNT_W'(LONG_MS);
    end else begin
      periodMs = CNT_W'(BASE_MS) << periodCode;
    end
  end

  assign halfMs     = periodMs >> 1;
  assign upperHalf  = (cnt >= halfMs);
  assign lastTick   = (cnt == (periodMs - CNT_W'(1)));
  assign cfgChanged = cfgWe && ((cfgPeriod != periodCode) || (cfgMode != modeBit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCode <= CODE_W'(RST_CODE);
      modeBit    <= 1'b0;
    end else if (cfgWe) begin
      periodCode <= cfgPeriod;
      modeBit    <= cfgMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.advance) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opMode,
  input  logic       disablePin,
  input  logic       trigger,
  input  logic       msTick,
  input  logic       modeBit,
  input  logic       upperHalf,
  input  logic       lastTick,
  input  logic       cfgChanged,
  output cntCmd_t    cmd,
  output wdKind_e    kindNow,
  output logic       modeChg,
  output logic       rstReq,
  output logic       offStatus
);

  logic [1:0] opModePrev;
  logic       pinPrev;
  logic       isOff;
  logic       restart;
  logic       earlyTrig;
  logic       expire;
  logic       pinRise;

  always_comb begin
    if (disablePin) begin
      kindNow = WD_OFF;
    end else begin
      case (opMode_e'(opMode))
        OP_NORMAL:  kindNow = modeBit ? WD_TIMEOUT : WD_WINDOW;
        OP_STANDBY: kindNow = modeBit ? WD_OFF : WD_TIMEOUT;
        default:    kindNow = WD_OFF;
      endcase
    end
  end

  assign isOff     = (kindNow == WD_OFF);
  assign modeChg   = (opMode != opModePrev);
  assign restart   = modeChg || cfgChanged;
  assign earlyTrig = !isOff && !restart && trigger && (kindNow == WD_WINDOW) && !upperHalf;
  assign expire    = !isOff && !restart && !trigger && msTick && lastTick;
  assign pinRise   = disablePin && !pinPrev;

  assign cmd.clear   = isOff || restart || trigger || expire;
  assign cmd.advance = msTick && !cmd.clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opModePrev <= opMode;
      pinPrev    <= 1'b0;
      rstReq     <= 1'b0;
      offStatus  <= 1'b0;
    end else begin
      opModePrev <= opMode;
      pinPrev    <= disablePin;
      rstReq     <= earlyTrig || expire || pinRise;
      offStatus  <= disablePin;
    end
  end

endmodule

// File: rtl/mode_watchdog.sv
module mode_watchdog
  import mwd_pkg::*;
#(
  parameter int BASE_MS    = 8,
  parameter int LONG_MS    = 1024,
  parameter int LONGEST_MS = 4096,
  parameter int RST_CODE   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       trigger,
  input  logic       cfgWe,
  input  logic [2:0] cfgPeriod,
  input  logic       cfgMode,
  input  logic [1:0] opMode,
  input  logic       disablePin,
  output logic       rstReq,
  output logic       offStatus,
  output logic [1:0] wdKind,
  output logic [2:0] periodCode,
  output logic       modeBit
);

  localparam int CODE_W = 3;
  localparam int CNT_W  = $clog2(LONGEST_MS + 1);

  cntCmd_t          cmd;
  wdKind_e          kindNow;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] periodMs;
  logic             upperHalf;
  logic             lastTick;
  logic             cfgChanged;
  logic             modeChg;

  mwd_datapath #(
    .CODE_W(CODE_W), .BASE_MS(BASE_MS), .LONG_MS(LONG_MS),
    .LONGEST_MS(LONGEST_MS), .RST_CODE(RST_CODE), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPeriod(cfgPeriod),
    .cfgMode(cfgMode), .cmd(cmd), .periodCode(periodCode), .modeBit(modeBit),
    .cnt(cntVal), .periodMs(periodMs), .upperHalf(upperHalf),
    .lastTick(lastTick), .cfgChanged(cfgChanged)
  );

  mwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .disablePin(disablePin),
    .trigger(trigger), .msTick(msTick), .modeBit(modeBit),
    .upperHalf(upperHalf), .lastTick(lastTick), .cfgChanged(cfgChanged),
    .cmd(cmd), .kindNow(kindNow), .modeChg(modeChg), .rstReq(rstReq),
    .offStatus(offStatus)
  );

  assign wdKind = kindNow;

endmodule

// File: rtl/mode_watchdog_checker.sv
module mode_watchdog_checker #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             trigger,
  input logic             cfgWe,
  input logic [2:0]       cfgPeriod,
  input logic             cfgMode,
  input logic [1:0]       opMode,
  input logic             disablePin,
  input logic             rstReq,
  input logic             offStatus,
  input logic [1:0]       wdKind,
  input logic [2:0]       periodCode,
  input logic             modeBit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodMs,
  input logic             modeChg
);

  logic cfgDiff;
  assign cfgDiff = cfgWe && ((cfgPeriod != periodCode) || (cfgMode != modeBit));

  a_r2_reset_defaults: assert property (@(posedge clk)
    !rstN |=> (periodCode == 3'd4 && !modeBit && cnt == '0));

  a_r6_cnt_below_period: assert property (@(posedge clk) disable iff (!rstN)
    cnt < periodMs);

  a_r5_early_trigger: assert property (@(posedge clk) disable iff (!rstN)
    (wdKind == 2'd1 && trigger && !modeChg && !cfgDiff && cnt < (periodMs >> 1)) |=> rstReq);

  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wdKind == 2'd0 && !disablePin) |=> !rstReq);

  a_r8_cfg_restart: assert property (@(posedge clk) disable iff (!rstN)
    cfgDiff |=> (cnt == '0));

  a_r8_mode_restart: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != $past(opMode)) |=> (cnt == '0));

  a_r7_pin_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disablePin) |=> rstReq);

  a_r7_status_follows: assert property (@(posedge clk) disable iff (!rstN)
    disablePin |=> offStatus);

  a_r4_sleep_held: assert property (@(posedge clk) disable iff (!rstN)
    (opMode[1] && $past(opMode[1])) |-> (cnt == '0 && wdKind == 2'd0));

endmodule

bind mode_watchdog mode_watchdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .trigger(trigger), .cfgWe(cfgWe),
  .cfgPeriod(cfgPeriod), .cfgMode(cfgMode), .opMode(opMode),
  .disablePin(disablePin), .rstReq(rstReq), .offStatus(offStatus),
  .wdKind(wdKind), .periodCode(periodCode), .modeBit(modeBit),
  .cnt(cntVal), .periodMs(periodMs), .modeChg(modeChg)
);

// File: tb/mode_watchdog_bench.sv
`timescale 1ns/1ps
module mode_watchdog_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       trigger = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgPeriod = 3'd0;
  logic       cfgMode = 1'b0;
  logic [1:0] opMode = 2'd1;
  logic       disablePin = 1'b0;
  logic       rstReq;
  logic       offStatus;
  logic [1:0] wdKind;
  logic [2:0] periodCode;
  logic       modeBit;

  int nChecks = 0;
  int nFail = 0;

  // reference model state
  int         mCnt;
  logic [2:0] mCode;
  logic       mBit;
  logic [1:0] mOpPrev;
  logic       mPinPrev;
  logic       expRst;
  logic       expOff;
  string      rstTag;
  logic [1:0] curOp;
  logic       curPin;

  always #2 clk = ~clk;

  mode_watchdog u_mode_watchdog (
    .clk(clk), .rstN(rstN), .msTick(msTick), .trigger(trigger),
    .cfgWe(cfgWe), .cfgPeriod(cfgPeriod), .cfgMode(cfgMode),
    .opMode(opMode), .disablePin(disablePin), .rstReq(rstReq),
    .offStatus(offStatus), .wdKind(wdKind), .periodCode(periodCode),
    .modeBit(modeBit)
  );

  function automatic int pms(input logic [2:0] c);
    case (c)
      3'd6:    return 1024;
      3'd7:    return 4096;
      default: return 8 << c;
    endcase
  endfunction

  function automatic logic [1:0] kindOf(input logic [1:0] op, input logic pin, input logic b);
    if (pin) return 2'd0;
    if (op == 2'd0) return b ? 2'd2 : 2'd1;
    if (op == 2'd1) return b ? 2'd0 : 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock cycle: check registered results, drive, check kind, update model
  task automatic step(input logic tr, input logic tk, input logic we,
                      input logic [2:0] cp, input logic cm);
    logic [1:0] k;
    int p;
    logic cfgCh, mchg, isOff, rsta, early, expire, rise;
    chk({rstTag, " rstReq"}, rstReq, expRst);
    chk("R7 offStatus", offStatus, expOff);
    chk("R2 periodCode", periodCode, mCode);
    chk("R2 modeBit", modeBit, mBit);
    trigger = tr; msTick = tk; cfgWe = we; cfgPeriod = cp; cfgMode = cm;
    opMode = curOp; disablePin = curPin;
    #1;
    k = kindOf(curOp, curPin, mBit);
    chk(curPin ? "R7 wdKind" : (curOp[1] ? "R4 wdKind" : "R3 wdKind"), wdKind, k);
    p = pms(mCode);
    cfgCh = we && (cp != mCode || cm != mBit);
    mchg = (curOp != mOpPrev);
    isOff = (k == 2'd0);
    rsta = mchg || cfgCh;
    early = !isOff && !rsta && tr && k == 2'd1 && mCnt < p / 2;
    expire = !isOff && !rsta && !tr && tk && mCnt == p - 1;
    rise = curPin && !mPinPrev;
    expRst = early || expire || rise;
    rstTag = early ? "R5" : expire ? "R6" : rise ? "R7" : rsta ? "R8" : isOff ? "R4" : "R9";
    if (isOff || rsta || tr || expire) mCnt = 0;
    else if (tk) mCnt++;
    if (we) begin mCode = cp; mBit = cm; end
    mOpPrev = curOp;
    mPinPrev = curPin;
    expOff = curPin;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    curOp = 2'd1; curPin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mCode = 3'd4; mBit = 1'b0; mOpPrev = 2'd1; mPinPrev = 1'b0;
    expRst = 1'b0; expOff = 1'b0; rstTag = "R2";
    chk("R2 reset code", periodCode, 4);
    chk("R2 reset bit", modeBit, 0);
    chk("R2 reset rstReq", rstReq, 0);
    chk("R3 standby bit0 timeout", wdKind, 2);

    // R1: expiry distance per period code in standby timeout
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2 || c == 3 || c == 4) continue;
      step(1'b0, 1'b0, 1'b1, 3'(c), 1'b0);
      n = 0;
      do begin ticks(1); n++; end while (!rstReq && n < 5000);
      chk($sformatf("R1 code %0d period", c), n, pms(3'(c)));
    end

    // R9: timeout trigger restarts
    step(1'b0, 1'b0, 1'b1, 3'd1, 1'b0);
    ticks(15);
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    chk("R9 trigger late in timeout", rstReq, 0);
    ticks(15);
    chk("R9 no expiry after restart", rstReq, 0);
    ticks(1);
    chk("R6 expiry after full period", rstReq, 1);

    // R3: standby with bit 1 is off
    step(1'b0, 1'b0, 1'b1, 3'd0, 1'b1);
    chk("R3 standby bit1 off", wdKind, 0);
    ticks(40);
    chk("R3 off gives no request", rstReq, 0);
    curOp = 2'd0;
    step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R3 normal bit1 timeout", wdKind, 2);

    // R5: window operation, 8 ms, half = 4
    step(1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
    chk("R3 normal bit0 window", wdKind, 1);
    ticks(3);
    step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R5 early trigger at 3 of 8", rstReq, 1);
    ticks(4);
    step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R5 trigger at half is legal", rstReq, 0);
    ticks(7);
    step(1'b0, 1'b1, 1'b1, 3'd1, 1'b0);
    chk("R8 cfg change suppresses expiry", rstReq, 0);
    ticks(15);
    curOp = 2'd1;
    step(1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    chk("R8 mode change suppresses expiry", rstReq, 0);
    ticks(15);
    chk("R8 count restarted at mode change", rstReq, 0);

    // R4: sleep and over-temperature
    curOp = 2'd2;
    ticks(50);
    chk("R4 sleep no request", rstReq, 0);
    curOp = 2'd3;
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    ticks(50);
    chk("R4 overtemp no request", rstReq, 0);
    chk("R4 overtemp kind", wdKind, 0);

    // R7: disable pin
    curOp = 2'd1;
    ticks(2);
    curPin = 1'b1;
    ticks(1);
    chk("R7 pin rise request", rstReq, 1);
    chk("R7 status set", offStatus, 1);
    ticks(40);
    chk("R7 pin held no request", rstReq, 0);
    chk("R7 kind off", wdKind, 0);
    curPin = 1'b0;
    ticks(1);
    chk("R7 status cleared", offStatus, 0);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 300 == 0) curOp = 2'($urandom % 4);
      if ($urandom % 700 == 0) curPin = !curPin;
      step(1'($urandom % 16 == 0), 1'($urandom % 2), 1'($urandom % 200 == 0),
           3'($urandom % 4), 1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule